// File: doc/BRIEF.md
# Double-Buffered Audio Block Sequencer

This block runs the buffer hand-off for a serial audio port that moves 32-bit words between memory and a serializer. Software programs a pending transmit pointer, a pending receive pointer and a block length in words, and picks one of three directions: receive only, transmit only, or both together. A start task loads the pending values into the working address counters. From then on, each word strobe from the serializer moves the working address of its direction forward by one word.

At every block boundary the pending pointers are copied into the working counters again. A pointer-updated event then tells software that the pending registers are free to be rewritten. If software has not rewritten them in time, the old pointer is loaded again and the same memory is used a second time. No error is flagged. A stop request never cuts a block short. It takes effect at the next boundary, where the sequencer raises a stopped event and freezes its counters. Event flags are sticky, and each flag has its own interrupt enable.

Top module: `audio_block_seq`

## Requirements
- R1: After reset, `running` is 0, both working addresses are 0, all three event flags are 0 and `irq` is 0.
- R2: A start task (bit 0 written to register 4) is accepted only if the enable bit (register 0 bit 0) is 1, the direction field (register 0 bits 2:1) is nonzero, and the sequencer is idle. In every other case it changes nothing.
- R3: On an accepted start, each enabled direction loads its pending pointer into its working address and sets its pointer event. The transmit event is bit 0 and the receive event is bit 1. Direction bit 1 enables transmit and direction bit 0 enables receive. A disabled direction neither loads nor raises its event.
- R4: Each accepted word strobe adds 4 to the working address of its direction. A strobe is ignored if its direction is disabled, if the sequencer is idle, or if that direction has already finished its words for the current block.
- R5: When the block completes and no stop is pending, each enabled direction reloads its working address from the pending pointer that was held before that clock edge and raises its pointer event. If the pending pointer was not rewritten, the same address is reused.
- R6: With both directions enabled, a block completes only after both directions have taken all of their words. No pointer event is raised before that.
- R7: A stop (bit 1 written to register 4 while running) takes effect at the next block completion, including a completion that happens in the same cycle as the stop write. At that point `running` falls, the stopped event (bit 2) is set, and the working addresses hold through any later strobes.
- R8: Event flags stay set until software writes a 1 to the matching bit of register 5. An event being set in the same cycle as its clear leaves the flag set.
- R9: `irq` is high exactly when some event flag is set and its enable bit in register 6 (same bit layout) is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register index: 0 control, 1 TX pending pointer, 2 RX pending pointer, 3 block words, 4 tasks, 5 event clear, 6 interrupt enable |
| wr_data | input | 32 | Register write data |
| tx_word | input | 1 | Serializer consumed one transmit word |
| rx_word | input | 1 | Serializer produced one receive word |
| running | output | 1 | Transfer in progress |
| tx_addr | output | AW | Working transmit address |
| rx_addr | output | AW | Working receive address |
| ev_tx_ptr | output | 1 | Transmit pointer-updated event flag |
| ev_rx_ptr | output | 1 | Receive pointer-updated event flag |
| ev_stopped | output | 1 | Stopped event flag |
| irq | output | 1 | Masked OR of the event flags |

## Verification
Two collisions can fall in the same cycle. The first is the strobe that completes a block meeting a software write to the event-clear register. The bench forces this by driving the clear write and both word strobes on the same clock edge, and it expects both pointer events to read as set afterwards. The second is a stop task written on the same edge as the completing strobe. For that case the bench expects `running` to fall at once, the stopped event to be set, and the addresses to sit one word past the end of the block with no reload.

// File: rtl/audio_block_seq.sv
module audio_block_seq #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [31:0]   wr_data,
  input  logic          tx_word,
  input  logic          rx_word,
  output logic          running,
  output logic [AW-1:0] tx_addr,
  output logic [AW-1:0] rx_addr,
  output logic          ev_tx_ptr,
  output logic          ev_rx_ptr,
  output logic          ev_stopped,
  output logic          irq
);
  localparam logic [2:0]    A_CTRL = 3'd0, A_TXP = 3'd1, A_RXP = 3'd2, A_WORDS = 3'd3;
  localparam logic [2:0]    A_TASK = 3'd4, A_EVCLR = 3'd5, A_IEN = 3'd6;
  localparam logic [AW-1:0] STEP = AW'(4);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic          en_q;
  logic [1:0]    dir_q, act_q;
  logic [AW-1:0] tx_pend_q, rx_pend_q, tx_ptr_q, rx_ptr_q;
  logic [CW-1:0] words_q, tx_cnt_q, rx_cnt_q;
  logic          run_q, stop_q, tx_rdy_q, rx_rdy_q;
  logic [2:0]    ev_q, ie_q;

  wire         wr_task   = wr_en && (wr_addr == A_TASK);
  wire         start_go  = wr_task && wr_data[0] && en_q && !run_q && (dir_q != 2'b00);
  wire         stop_now  = stop_q || (wr_task && wr_data[1]);
  wire         tx_go     = run_q && act_q[1] && tx_word && !tx_rdy_q;
  wire         rx_go     = run_q && act_q[0] && rx_word && !rx_rdy_q;
  wire         tx_last   = tx_go && (tx_cnt_q <= ONE);
  wire         rx_last   = rx_go && (rx_cnt_q <= ONE);
  wire         complete  = (tx_last || rx_last)
                         && (!act_q[1] || tx_rdy_q || tx_last)
                         && (!act_q[0] || rx_rdy_q || rx_last);
  wire         finish    = complete && stop_now;
  wire         reload    = start_go || (complete && !stop_now);
  wire [1:0]   act_next  = start_go ? dir_q : act_q;
  wire [2:0]   ev_clr    = (wr_en && wr_addr == A_EVCLR) ? wr_data[2:0] : 3'b000;
  wire [2:0]   ev_set    = {finish, reload && act_next[0], reload && act_next[1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      dir_q     <= 2'b00;
      tx_pend_q <= '0;
      rx_pend_q <= '0;
      words_q   <= ONE;
      ie_q      <= 3'b000;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL:  begin en_q <= wr_data[0]; dir_q <= wr_data[2:1]; end
        A_TXP:   tx_pend_q <= wr_data[AW-1:0];
        A_RXP:   rx_pend_q <= wr_data[AW-1:0];
        A_WORDS: words_q   <= wr_data[CW-1:0];
        A_IEN:   ie_q      <= wr_data[2:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      stop_q <= 1'b0;
      act_q  <= 2'b00;
    end else begin
      if (start_go) begin
        run_q <= 1'b1;
        act_q <= dir_q;
      end else if (finish) begin
        run_q <= 1'b0;
      end
      if (start_go || finish)
        stop_q <= 1'b0;
      else if (run_q && wr_task && wr_data[1])
        stop_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_ptr_q <= '0;
      tx_cnt_q <= '0;
      tx_rdy_q <= 1'b0;
    end else if (reload) begin
      tx_rdy_q <= 1'b0;
      if (act_next[1]) begin
        tx_ptr_q <= tx_pend_q;
        tx_cnt_q <= words_q;
      end
    end else if (tx_go) begin
      tx_ptr_q <= tx_ptr_q + STEP;
      tx_cnt_q <= tx_cnt_q - ONE;
      if (tx_last) tx_rdy_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_ptr_q <= '0;
      rx_cnt_q <= '0;
      rx_rdy_q <= 1'b0;
    end else if (reload) begin
      rx_rdy_q <= 1'b0;
      if (act_next[0]) begin
        rx_ptr_q <= rx_pend_q;
        rx_cnt_q <= words_q;
      end
    end else if (rx_go) begin
      rx_ptr_q <= rx_ptr_q + STEP;
      rx_cnt_q <= rx_cnt_q - ONE;
      if (rx_last) rx_rdy_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ev_q <= 3'b000;
    else        ev_q <= (ev_q & ~ev_clr) | ev_set;
  end

  assign running    = run_q;
  assign tx_addr    = tx_ptr_q;
  assign rx_addr    = rx_ptr_q;
  assign ev_tx_ptr  = ev_q[0];
  assign ev_rx_ptr  = ev_q[1];
  assign ev_stopped = ev_q[2];
  assign irq        = |(ev_q & ie_q);

  a_r3_tx_evt_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev_q[0]) |-> act_q[1]);
  a_r3_rx_evt_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev_q[1]) |-> act_q[0]);
  a_r4_word_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_go && !reload) |=> tx_ptr_q == $past(tx_ptr_q) + STEP);
  a_r6_not_both_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> !(tx_rdy_q && rx_rdy_q));
  a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !start_go) |=> ($stable(tx_ptr_q) && $stable(rx_ptr_q)));
  a_r7_stopped_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev_q[2]) |-> !run_q);
  a_r8_sticky_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_q[2] && !ev_clr[2]) |=> ev_q[2]);
endmodule

// File: tb/test_audio_block_seq.sv
module test_audio_block_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        tx_word = 1'b0, rx_word = 1'b0;
  logic        running, ev_tx_ptr, ev_rx_ptr, ev_stopped, irq;
  logic [31:0] tx_addr, rx_addr;
  int          errors = 0, checks = 0;

  audio_block_seq i_audio_block_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tx_word(tx_word), .rx_word(rx_word), .running(running),
    .tx_addr(tx_addr), .rx_addr(rx_addr), .ev_tx_ptr(ev_tx_ptr),
    .ev_rx_ptr(ev_rx_ptr), .ev_stopped(ev_stopped), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  // vector: {dir[2], tx_ptr[16], rx_ptr[16], words[8]}
  localparam logic [41:0] VEC [5] = '{
    {2'd3, 16'h0100, 16'h0800, 8'd3},
    {2'd2, 16'h2000, 16'h3000, 8'd1},
    {2'd1, 16'h0040, 16'h4000, 8'd5},
    {2'd3, 16'hFFF0, 16'h0010, 8'd2},
    {2'd2, 16'h0500, 16'h0000, 8'd4}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic stb(input logic t, input logic r);
    tx_word = t; rx_word = r;
    @(negedge clk);
    tx_word = 1'b0; rx_word = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] exp_tx, exp_rx;
    exp_tx = 0; exp_rx = 0;
    repeat (3) @(negedge clk);
    chk("R1 running", {31'd0, running}, 0);
    chk("R1 tx_addr", tx_addr, 0);
    chk("R1 rx_addr", rx_addr, 0);
    chk("R1 events", {29'd0, ev_stopped, ev_rx_ptr, ev_tx_ptr}, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < 5; v++) begin
      logic [1:0] d; logic [31:0] tp, rp; int n;
      d = VEC[v][41:40]; tp = {16'd0, VEC[v][39:24]};
      rp = {16'd0, VEC[v][23:8]}; n = int'(VEC[v][7:0]);
      wr(3'd0, {29'd0, d, 1'b1});
      wr(3'd1, tp); wr(3'd2, rp); wr(3'd3, n);
      wr(3'd5, 7);
      wr(3'd4, 1);
      if (d[1]) exp_tx = tp;
      if (d[0]) exp_rx = rp;
      chk("R2 start accepted", {31'd0, running}, 1);
      chk("R3 tx load", tx_addr, exp_tx);
      chk("R3 rx load", rx_addr, exp_rx);
      chk("R3 events by dir", {30'd0, ev_rx_ptr, ev_tx_ptr}, {30'd0, d[0], d[1]});
      wr(3'd4, 2);
      for (int k = 0; k < n; k++) stb(1'b1, 1'b1);
      if (d[1]) exp_tx = tp + 4 * n;
      if (d[0]) exp_rx = rp + 4 * n;
      chk("R7 stopped at boundary", {30'd0, running, ev_stopped}, 1);
      chk("R4 tx advance", tx_addr, exp_tx);
      chk("R4 rx advance", rx_addr, exp_rx);
    end

    wr(3'd0, 32'd6); wr(3'd4, 1);
    chk("R2 start without enable", {31'd0, running}, 0);
    wr(3'd0, 32'd1); wr(3'd4, 1);
    chk("R2 start with zero dir", {31'd0, running}, 0);
    chk("R2 no load", tx_addr, exp_tx);

    wr(3'd0, 32'd5); wr(3'd1, 32'h1000); wr(3'd3, 4); wr(3'd5, 7); wr(3'd4, 1);
    chk("R3 tx only start", tx_addr, 32'h1000);
    stb(1, 0); stb(1, 0);
    chk("R4 two words", tx_addr, 32'h1008);
    wr(3'd4, 1);
    chk("R2 start while running", tx_addr, 32'h1008);
    stb(0, 1);
    chk("R4 disabled rx ignored", rx_addr, exp_rx);
    wr(3'd5, 7);
    stb(1, 0); stb(1, 0);
    chk("R5 reuse pointer", tx_addr, 32'h1000);
    chk("R5 tx event again", {30'd0, ev_rx_ptr, ev_tx_ptr}, 1);
    wr(3'd1, 32'h1200);
    for (int k = 0; k < 4; k++) stb(1, 0);
    chk("R5 new pointer", tx_addr, 32'h1200);
    chk("R9 no enables", {31'd0, irq}, 0);
    wr(3'd6, 4);
    chk("R9 masked event", {31'd0, irq}, 0);
    wr(3'd6, 1);
    chk("R9 enabled event", {31'd0, irq}, 1);
    wr(3'd6, 0);
    wr(3'd4, 2);
    for (int k = 0; k < 4; k++) stb(1, 0);
    chk("R7 tx stop", {30'd0, running, ev_stopped}, 1);
    chk("R7 tx end addr", tx_addr, 32'h1210);
    stb(1, 0);
    chk("R7 hold after stop", tx_addr, 32'h1210);

    wr(3'd0, 32'd7); wr(3'd1, 32'h2000); wr(3'd2, 32'h3000); wr(3'd3, 2);
    wr(3'd4, 1); wr(3'd5, 7);
    stb(1, 0); stb(1, 0);
    chk("R6 tx done alone", tx_addr, 32'h2008);
    chk("R6 no event yet", {30'd0, ev_rx_ptr, ev_tx_ptr}, 0);
    stb(1, 0);
    chk("R4 finished dir ignored", tx_addr, 32'h2008);
    stb(0, 1); stb(0, 1);
    chk("R6 tx reload", tx_addr, 32'h2000);
    chk("R6 rx reload", rx_addr, 32'h3000);
    chk("R6 both events", {30'd0, ev_rx_ptr, ev_tx_ptr}, 3);
    wr(3'd5, 1);
    chk("R8 selective clear", {30'd0, ev_rx_ptr, ev_tx_ptr}, 2);
    wr(3'd5, 3);
    stb(1, 1);
    wr_en = 1'b1; wr_addr = 3'd5; wr_data = 3; tx_word = 1'b1; rx_word = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tx_word = 1'b0; rx_word = 1'b0;
    chk("R8 set beats clear", {30'd0, ev_rx_ptr, ev_tx_ptr}, 3);
    stb(1, 1);
    wr_en = 1'b1; wr_addr = 3'd4; wr_data = 2; tx_word = 1'b1; rx_word = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tx_word = 1'b0; rx_word = 1'b0;
    chk("R7 same-cycle stop", {30'd0, running, ev_stopped}, 1);
    chk("R7 tx end", tx_addr, 32'h2008);
    chk("R7 rx end", rx_addr, 32'h3008);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule